// File: doc/BRIEF.md
# 24-Hour BCD Time-of-Day Clock with Multiplexed Display

This block keeps the time of day as six BCD digits (hours, minutes and seconds, each as a tens and a units digit) and counts in a 24-hour cycle. Everything runs on one system clock. A one-cycle `sec_tick` enable advances the seconds. Two adjust inputs let the user step the minutes or the hours directly. An asynchronous, active-high reset clears the whole time to 00:00:00.

Seconds and minutes are each a pair of linked BCD digits. When a pair passes from 59 to 00 it raises a registered carry for one cycle, and that carry steps the next pair on the following clock edge. The hour pair counts 00 to 23 and then returns to 00.

The block also drives a scanned seven-segment display. A 3-bit select code walks through digit positions 0 to 5, advancing once for each `scan_tick` enable. The segment bus carries the decoded pattern of the digit at the selected position. No data stream crosses the boundary: every input is a plain per-cycle control, and the block applies no back-pressure.

Top module: `tod_bcd_clock`

## Requirements
- R1: Each cycle with `sec_tick` high advances the seconds by one. The seconds units digit counts 0 to 9 and, on leaving 9, returns to 0 and steps the tens digit. The tens digit counts 0 to 5. Seconds 59 are followed by 00.
- R2: The edge that takes the seconds from 59 to 00 leaves the minutes unchanged. The minutes advance by one on the next clock edge, through a carry that is high for exactly one cycle.
- R3: The minutes count 00 to 59 with the same digit rules as R1. When the minutes wrap from 59 to 00 because of a seconds carry, the hours advance by one on the next clock edge, through a one-cycle carry.
- R4: The hours count 00 to 23 in BCD and wrap from 23 to 00. The units digit wraps at 9, except that it wraps at 3 when the tens digit is 2. 23:59:59 is followed by 00:00:00 once the carries have settled.
- R5: Each cycle with `adj_min` high advances the minutes by one, modulo 60. A wrap caused this way never advances the hours, and `adj_min` leaves the seconds unchanged.
- R6: Each cycle with `adj_hour` high advances the hours by one, modulo 24. `adj_hour` leaves the minutes and seconds unchanged.
- R7: While `rst` is high, all six digits read 0 and `sel_o` reads 0. These values appear at once, without waiting for a clock edge.
- R8: `time_bcd_o` is {hours tens, hours units, minutes tens, minutes units, seconds tens, seconds units}, 4 bits each, with the hours tens digit in bits 23:20 and the seconds units digit in bits 3:0.
- R9: `sel_o` advances by one on each clock edge where `scan_tick` is high, goes from 5 back to 0, never holds a value above 5, and holds its value when `scan_tick` is low.
- R10: `seg_o` shows the digit at position `sel_o`. Positions 0 to 5 are: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens. The pattern is active high, with bit 0 driving segment a through bit 6 driving segment g. The digits 0 to 9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R11: When there is no tick, no adjust request and no pending carry, the time does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high clear |
| sec_tick | input | 1 | One-second enable, one cycle wide |
| scan_tick | input | 1 | Display scan enable |
| adj_min | input | 1 | Minute step request, one step per cycle high |
| adj_hour | input | 1 | Hour step request, one step per cycle high |
| time_bcd_o | output | 24 | Current time as six BCD digits |
| sel_o | output | 3 | Selected display position, 0 to 5 |
| seg_o | output | 7 | Active-high segment pattern, a in bit 0 |

## Verification
The bench focuses on the carry timing at the pair boundaries. It checks that the minutes stay put on the edge where the seconds wrap and move on the edge after. A design with a combinational carry would move both in the same cycle, and a design with a sticky carry would add extra minutes. The bench steps the hours across 09→10, 19→20 and 23→00. A units digit that wraps at the wrong count would show 24:00 or skip 20 to 29. It also wraps the minutes through `adj_min` and checks that the hours stay put; a design that let the adjust feed the minute carry would advance the hour. Finally it scans through all six positions and back to 0, which catches a select that runs on to 6 or 7, or digits fed to the wrong position.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 6;
  localparam int TIME_W     = NUM_DIGITS * DIGIT_W;
  localparam int SEL_W      = 3;
  localparam int SEG_W      = 7;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // position of each digit on the scanned display
  typedef enum logic [SEL_W-1:0] {
    POS_SEC_U  = 3'd0,
    POS_SEC_T  = 3'd1,
    POS_MIN_U  = 3'd2,
    POS_MIN_T  = 3'd3,
    POS_HOUR_U = 3'd4,
    POS_HOUR_T = 3'd5
  } disp_pos_e;
endpackage

// File: rtl/tod_bcd_pair.sv
module tod_bcd_pair
  import tod_pkg::*;
#(
  parameter int TENS_TOP  = 5,
  parameter int UNITS_TOP = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic carry_en_i,
  output bcd_t units_o,
  output bcd_t tens_o,
  output logic carry_o
);
  localparam bcd_t TENS_LAST  = bcd_t'(TENS_TOP);
  localparam bcd_t UNITS_LAST = bcd_t'(UNITS_TOP);
  localparam bcd_t NINE       = bcd_t'(9);

  bcd_t units_q, tens_q;
  logic carry_q;
  logic at_top;

  assign at_top = (tens_q == TENS_LAST) && (units_q == UNITS_LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      units_q <= '0;
      tens_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      carry_q <= step_i & carry_en_i & at_top;
      if (step_i) begin
        if (at_top) begin
          units_q <= '0;
          tens_q  <= '0;
        end else if (units_q == NINE) begin
          units_q <= '0;
          tens_q  <= tens_q + bcd_t'(1);
        end else begin
          units_q <= units_q + bcd_t'(1);
        end
      end
    end
  end

  assign units_o = units_q;
  assign tens_o  = tens_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/tod_seg_decode.sv
module tod_seg_decode
  import tod_pkg::*;
(
  input  bcd_t             digit_i,
  output logic [SEG_W-1:0] seg_o
);
  // active high, bit 0 = segment a ... bit 6 = segment g; 10..15 blank
  always_comb begin
    case (digit_i)
      4'd0:    seg_o = 7'h3F;
      4'd1:    seg_o = 7'h06;
      4'd2:    seg_o = 7'h5B;
      4'd3:    seg_o = 7'h4F;
      4'd4:    seg_o = 7'h66;
      4'd5:    seg_o = 7'h6D;
      4'd6:    seg_o = 7'h7D;
      4'd7:    seg_o = 7'h07;
      4'd8:    seg_o = 7'h7F;
      4'd9:    seg_o = 7'h6F;
      default: seg_o = '0;
    endcase
  end
endmodule

// File: rtl/tod_scan_mux.sv
module tod_scan_mux
  import tod_pkg::*;
#(
  parameter int N_POS = NUM_DIGITS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scan_tick,
  input  logic [N_POS*DIGIT_W-1:0] digits_i,
  output logic [SEL_W-1:0]         sel_o,
  output bcd_t                     digit_o
);
  localparam logic [SEL_W-1:0] LAST_POS = SEL_W'(N_POS - 1);

  logic [SEL_W-1:0] sel_q;
  bcd_t             dig_arr [N_POS];

  for (genvar g = 0; g < N_POS; g++) begin : g_slot
    assign dig_arr[g] = digits_i[g*DIGIT_W +: DIGIT_W];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sel_q <= '0;
    end else if (scan_tick) begin
      sel_q <= (sel_q == LAST_POS) ? '0 : sel_q + SEL_W'(1);
    end
  end

  always_comb begin
    digit_o = '0;
    for (int i = 0; i < N_POS; i++) begin
      if (sel_q == SEL_W'(i)) digit_o = dig_arr[i];
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/tod_bcd_clock.sv
module tod_bcd_clock
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              scan_tick,
  input  logic              adj_min,
  input  logic              adj_hour,
  output logic [TIME_W-1:0] time_bcd_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [SEG_W-1:0]  seg_o
);
  bcd_t sec_u, sec_t, min_u, min_t, hour_u, hour_t;
  logic sec_carry, min_carry, hour_wrap_unused;
  logic min_step, hour_step;
  bcd_t shown_digit;
  logic [TIME_W-1:0] digits;

  tod_bcd_pair #(.TENS_TOP(5), .UNITS_TOP(9)) u_sec (
    .clk(clk), .rst(rst), .step_i(sec_tick), .carry_en_i(1'b1),
    .units_o(sec_u), .tens_o(sec_t), .carry_o(sec_carry)
  );

  // adjust steps the minutes but may not feed the hour carry
  assign min_step = sec_carry | adj_min;

  tod_bcd_pair #(.TENS_TOP(5), .UNITS_TOP(9)) u_min (
    .clk(clk), .rst(rst), .step_i(min_step), .carry_en_i(sec_carry),
    .units_o(min_u), .tens_o(min_t), .carry_o(min_carry)
  );

  assign hour_step = min_carry | adj_hour;

  tod_bcd_pair #(.TENS_TOP(2), .UNITS_TOP(3)) u_hour (
    .clk(clk), .rst(rst), .step_i(hour_step), .carry_en_i(1'b0),
    .units_o(hour_u), .tens_o(hour_t), .carry_o(hour_wrap_unused)
  );

  assign digits     = {hour_t, hour_u, min_t, min_u, sec_t, sec_u};
  assign time_bcd_o = digits;

  tod_scan_mux #(.N_POS(NUM_DIGITS)) u_scan (
    .clk(clk), .rst(rst), .scan_tick(scan_tick),
    .digits_i(digits), .sel_o(sel_o), .digit_o(shown_digit)
  );

  tod_seg_decode u_dec (
    .digit_i(shown_digit), .seg_o(seg_o)
  );
endmodule

// File: rtl/tod_bcd_clock_chk.sv
module tod_bcd_clock_chk
  import tod_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              scan_tick,
  input logic              adj_min,
  input logic              adj_hour,
  input logic [TIME_W-1:0] time_bcd,
  input logic [SEL_W-1:0]  sel,
  input logic              sec_carry,
  input logic              min_carry
);
  // R9
  sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    sel <= 3'd5);

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !scan_tick |=> $stable(sel));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && time_bcd[7:0] == 8'h59) |=> (time_bcd[7:0] == 8'h00 && sec_carry));

  // R2
  sec_carry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sec_carry |=> !sec_carry);

  // R3
  min_carry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    min_carry |=> !min_carry);

  // R4
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    (time_bcd[23:16] <= 8'h23) && (time_bcd[19:16] <= 4'd9));

  // R5
  adj_min_sec_chk: assert property (@(posedge clk) disable iff (rst)
    (adj_min && !sec_tick) |=> $stable(time_bcd[7:0]));

  // R5
  adj_min_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (adj_min && !sec_carry) |=> !min_carry);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !adj_min && !adj_hour && !sec_carry && !min_carry) |=> $stable(time_bcd));
endmodule

bind tod_bcd_clock tod_bcd_clock_chk chk_i (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .scan_tick(scan_tick),
  .adj_min(adj_min), .adj_hour(adj_hour), .time_bcd(time_bcd_o),
  .sel(sel_o), .sec_carry(sec_carry), .min_carry(min_carry)
);

// File: tb/tod_bcd_clock_tb.sv
module tod_bcd_clock_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0, scan_tick = 1'b0, adj_min = 1'b0, adj_hour = 1'b0;
  logic [23:0] time_bcd_o;
  logic [2:0]  sel_o;
  logic [6:0]  seg_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_ss = 0, m_mm = 0, m_hh = 0, m_sel = 0;
  bit m_pm = 1'b0, m_ph = 1'b0;

  always #4 clk = ~clk;

  tod_bcd_clock dut_i (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .scan_tick(scan_tick),
    .adj_min(adj_min), .adj_hour(adj_hour),
    .time_bcd_o(time_bcd_o), .sel_o(sel_o), .seg_o(seg_o)
  );

  function automatic logic [6:0] seg_of(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [23:0] pack(input int h, input int m, input int s);
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  function automatic int digit_at(input int p);
    case (p)
      0: return m_ss % 10; 1: return m_ss / 10;
      2: return m_mm % 10; 3: return m_mm / 10;
      4: return m_hh % 10; default: return m_hh / 10;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced at each edge
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_ss = 0; m_mm = 0; m_hh = 0; m_sel = 0; m_pm = 0; m_ph = 0;
    end else begin
      bit npm, nph;
      npm = sec_tick && (m_ss == 59);
      nph = m_pm && (m_mm == 59);
      if (sec_tick) m_ss = (m_ss + 1) % 60;
      if (m_pm || adj_min) m_mm = (m_mm + 1) % 60;
      if (m_ph || adj_hour) m_hh = (m_hh + 1) % 24;
      m_pm = npm; m_ph = nph;
      if (scan_tick) m_sel = (m_sel + 1) % 6;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [23:0] e;
      e = pack(m_hh, m_mm, m_ss);
      check(time_bcd_o[7:0] == e[7:0], "R1 seconds", time_bcd_o, e);
      check(time_bcd_o[15:8] == e[15:8], "R3 minutes", time_bcd_o, e);
      check(time_bcd_o[23:16] == e[23:16], "R4 hours", time_bcd_o, e);
      check(sel_o == 3'(m_sel), "R9 select", 24'(sel_o), 24'(m_sel));
      check(seg_o == seg_of(digit_at(m_sel)), "R10 segments", 24'(seg_o),
            24'(seg_of(digit_at(m_sel))));
    end
  end

  task automatic step(input bit t, input bit sc, input bit am, input bit ah);
    sec_tick = t; scan_tick = sc; adj_min = am; adj_hour = ah;
    @(negedge clk);
    sec_tick = 0; scan_tick = 0; adj_min = 0; adj_hour = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(time_bcd_o == 24'h0 && sel_o == 3'd0, "R7 reset", time_bcd_o, 24'h0);
    check(seg_o == 7'h3F, "R10 digit 0 pattern", 24'(seg_o), 24'h3F);

    // R2: seconds wrap, minute follows one edge later
    repeat (60) step(1, 0, 0, 0);
    check(time_bcd_o == 24'h000000, "R2 minute held on wrap edge", time_bcd_o, 24'h000000);
    step(0, 0, 0, 0);
    check(time_bcd_o == 24'h000100, "R2 minute after carry", time_bcd_o, 24'h000100);

    // R11: idle hold
    repeat (8) step(0, 0, 0, 0);
    check(time_bcd_o == 24'h000100, "R11 idle hold", time_bcd_o, 24'h000100);

    // R5: minute adjust, R8 field layout
    repeat (7) step(1, 0, 0, 0);
    repeat (58) step(0, 0, 1, 0);
    check(time_bcd_o == 24'h005907, "R8 layout / R5 adjust", time_bcd_o, 24'h005907);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    check(time_bcd_o == 24'h000007, "R5 wrap without hour", time_bcd_o, 24'h000007);

    // R6: hour adjust, 09->10, 19->20, 23->00
    repeat (10) step(0, 0, 0, 1);
    check(time_bcd_o == 24'h100007, "R6 hour 10", time_bcd_o, 24'h100007);
    repeat (13) step(0, 0, 0, 1);
    check(time_bcd_o == 24'h230007, "R6 hour 23", time_bcd_o, 24'h230007);
    step(0, 0, 0, 1);
    check(time_bcd_o == 24'h000007, "R6 hour wrap", time_bcd_o, 24'h000007);

    // R4: midnight rollover with carries settling
    repeat (23) step(0, 0, 0, 1);
    repeat (59) step(0, 0, 1, 0);
    repeat (52) step(1, 0, 0, 0);
    check(time_bcd_o == 24'h235959, "R4 before midnight", time_bcd_o, 24'h235959);
    step(1, 0, 0, 0);
    check(time_bcd_o == 24'h235900, "R4 seconds wrapped", time_bcd_o, 24'h235900);
    step(0, 0, 0, 0);
    check(time_bcd_o == 24'h230000, "R3 minutes wrapped", time_bcd_o, 24'h230000);
    step(0, 0, 0, 0);
    check(time_bcd_o == 24'h000000, "R4 midnight", time_bcd_o, 24'h000000);

    // R9/R10: scan through 12:34:56
    repeat (12) step(0, 0, 0, 1);
    repeat (34) step(0, 0, 1, 0);
    repeat (56) step(1, 0, 0, 0);
    for (int p = 0; p < 8; p++) begin
      check(sel_o == 3'(p % 6), "R9 scan order", 24'(sel_o), 24'(p % 6));
      check(seg_o == seg_of(6 - (p % 6)), "R10 scanned digit", 24'(seg_o),
            24'(seg_of(6 - (p % 6))));
      step(0, 1, 0, 0);
    end

    // R7: asynchronous clear mid-run
    #1 rst = 1'b1;
    #1 check(time_bcd_o == 24'h0 && sel_o == 3'd0, "R7 async clear", time_bcd_o, 24'h0);
    @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk);

    // R1/R3/R4: a full day of back-to-back ticks
    for (int i = 0; i < 86420; i++) step(1, (i % 3) == 0, 0, 0);

    // mixed random traffic
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom % 100;
      step(r < 40, r > 60, r >= 40 && r < 45, r >= 45 && r < 48);
    end

    finish_run();
  end
endmodule